// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block governs one local scan port that sits behind a hierarchical test-access bridge. It decides, cycle by cycle, whether the port is taking part in scans or is parked. It also generates the local TMS stream, so that the local TAP controller always comes to rest in a known state: either Pause-DR or Test-Logic-Reset. The bridge supplies decoded one-cycle commands (park in Pause-DR, return to wait, soft reset), a port-select level, its own TAP state and its TMS. The block returns the local TMS, a local TCK enable and an in-chain flag that the scan-path multiplexer uses.

While the port is unparked, the local TAP tracks the bridge TAP exactly. To park the port in Pause-DR, the block waits for the bridge to reach Update-DR and then walks the local TAP to Pause-DR on its own. To park it in Test-Logic-Reset, the block holds TMS high for a fixed number of local clocks and then stops the local clock.

The block unparks an armed port only at a point where the local and bridge TAPs line up: Pause-DR for a port parked there, and Run-Test/Idle for a port parked in Test-Logic-Reset. The block carries no data stream. Every pin is a plain control level or a one-cycle pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `lp_park_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the port is in the Parked-TLR state: loc_tms is 1, loc_tck_en is 1 and in_chain is 0.
- R2: in_chain is 1 exactly while the port is unparked or is waiting to begin its parking walk. It is 0 in both parked states and during the walk.
- R3: While unparked, loc_tms repeats brg_tms. It is captured on each falling edge of clk, and loc_tck_en is 1.
- R4: A park pulse on an unparked port makes it wait, still in the chain, until brg_state equals 4'h5 (Update-DR). On that falling edge and the next three, loc_tms is 1, 0, 1, 0. The port is then Parked-Pause.
- R5: Parked-Pause drives loc_tms 0 and loc_tck_en 0 unless an unpark is taking place.
- R6: An armed Parked-Pause port unparks in a cycle where brg_state equals 4'h3 (Pause-DR). In that cycle loc_tms repeats brg_tms and loc_tck_en is 1.
- R7: An armed Parked-TLR port whose hold has completed unparks in a cycle where brg_state equals 4'hC (Run-Test/Idle) and brg_tms is 0. In that cycle loc_tms is 0 and loc_tck_en is 1.
- R8: On entry to Parked-TLR, loc_tms is 1 and loc_tck_en is 1 for TLR_HOLD (default 5) rising edges. After that, loc_tck_en is 0 while loc_tms stays 1.
- R9: A return-to-wait pulse moves an unparked or parking port to Parked-TLR. It leaves a parked port where it is, and it clears any armed unpark.
- R10: A soft-reset pulse moves the port from any state to Parked-TLR, clears the arm and restarts the hold count.
- R11: A park pulse arms a parked port only when port_sel is 1. With port_sel 0 it has no effect on a parked port, and it has no effect during a parking walk.
- R12: When pulses coincide, soft reset wins over return-to-wait, and return-to-wait wins over park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge test clock |
| rst_n | input | 1 | Bridge-level reset, active low, asynchronous |
| cmd_park_pause | input | 1 | Park-in-Pause command pulse |
| cmd_goto_wait | input | 1 | Return-to-wait command pulse |
| cmd_soft_reset | input | 1 | Soft-reset command pulse |
| port_sel | input | 1 | This port is selected for unparking |
| brg_state | input | 4 | Current bridge TAP state (0xC Run-Test/Idle, 0x3 Pause-DR, 0x5 Update-DR) |
| brg_tms | input | 1 | Bridge TMS |
| loc_tms | output | 1 | Local TMS, updated on the falling edge |
| loc_tck_en | output | 1 | Local TCK enable for the next rising edge |
| in_chain | output | 1 | Port is part of the active scan chain |

## Verification
The hardest case to reach is unparking from Parked-TLR. Four conditions must line up in one cycle: the port must have been armed by a selected park pulse, the TMS-high hold must have run out, the bridge must report Run-Test/Idle, and bridge TMS must be low. The stimulus drives brg_state directly, so a scripted sequence arms the port after the hold, presents Run-Test/Idle, and then repeats the attempt right after a coincident command that must not arm it. A long random phase then weights brg_state towards Run-Test/Idle, Pause-DR and Update-DR, so that arming, walks and unparks recur against a behavioural model that is compared on every clock.

// File: rtl/lp_park_pkg.sv
`timescale 1ns/1ps
package lp_park_pkg;

  typedef enum logic [1:0] {
    ST_UNPARKED     = 2'd0,
    ST_PARK_SEQ     = 2'd1,
    ST_PARKED_PAUSE = 2'd2,
    ST_PARKED_TLR   = 2'd3
  } park_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PARK = 2'd1,
    CMD_WAIT = 2'd2,
    CMD_SOFT = 2'd3
  } park_cmd_e;

  localparam int TAP_W = 4;
  localparam logic [TAP_W-1:0] TAP_RTI       = 4'hC;
  localparam logic [TAP_W-1:0] TAP_PAUSE_DR  = 4'h3;
  localparam logic [TAP_W-1:0] TAP_UPDATE_DR = 4'h5;

  // Update-DR -> Select-DR -> Capture-DR -> Exit1-DR -> Pause-DR
  localparam int WALK_LEN = 4;
  localparam int WALK_W   = $clog2(WALK_LEN);

endpackage

// File: rtl/lp_cmd_arb.sv
`timescale 1ns/1ps
module lp_cmd_arb
  import lp_park_pkg::*;
(
  input  logic      park_i,
  input  logic      wait_i,
  input  logic      soft_i,
  output park_cmd_e cmd_o
);

  always_comb begin
    if (soft_i)      cmd_o = CMD_SOFT;
    else if (wait_i) cmd_o = CMD_WAIT;
    else if (park_i) cmd_o = CMD_PARK;
    else             cmd_o = CMD_NONE;
  end

endmodule

// File: rtl/lp_park_fsm.sv
`timescale 1ns/1ps
module lp_park_fsm
  import lp_park_pkg::*;
#(
  parameter int HOLD = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  park_cmd_e         cmd,
  input  logic              port_sel,
  input  logic [TAP_W-1:0]  brg_state,
  input  logic              brg_tms,
  output park_st_e          st,
  output logic [WALK_W-1:0] walk,
  output logic              arm,
  output logic              hold_done,
  output logic              unpark_go,
  output logic              walk_go
);

  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0]     HOLD_V    = HW'(HOLD);
  localparam logic [WALK_W-1:0] WALK_LAST = WALK_W'(WALK_LEN - 1);

  park_st_e          st_n;
  logic [WALK_W-1:0] walk_n;
  logic              arm_n;
  logic [HW-1:0]     hold_cnt, hold_n;
  logic              kill;

  assign hold_done = (hold_cnt == HOLD_V);
  assign kill      = (cmd == CMD_SOFT) || (cmd == CMD_WAIT);

  always_comb begin
    unpark_go = !kill && arm &&
                (((st == ST_PARKED_PAUSE) && (brg_state == TAP_PAUSE_DR)) ||
                 ((st == ST_PARKED_TLR) && hold_done &&
                  (brg_state == TAP_RTI) && !brg_tms));
    walk_go   = !kill && (st == ST_PARK_SEQ) && (walk == '0) &&
                (brg_state == TAP_UPDATE_DR);
  end

  always_comb begin
    st_n   = st;
    walk_n = walk;
    arm_n  = arm;
    hold_n = hold_cnt;
    if ((st == ST_PARKED_TLR) && !hold_done) hold_n = hold_cnt + HW'(1);

    if (cmd == CMD_SOFT) begin
      st_n   = ST_PARKED_TLR;
      walk_n = '0;
      arm_n  = 1'b0;
      hold_n = '0;
    end else if (cmd == CMD_WAIT) begin
      arm_n = 1'b0;
      if ((st == ST_UNPARKED) || (st == ST_PARK_SEQ)) begin
        st_n   = ST_PARKED_TLR;
        walk_n = '0;
        hold_n = '0;
      end
    end else if (unpark_go) begin
      st_n  = ST_UNPARKED;
      arm_n = 1'b0;
    end else begin
      case (st)
        ST_UNPARKED: begin
          if (cmd == CMD_PARK) begin
            st_n   = ST_PARK_SEQ;
            walk_n = '0;
          end
        end
        ST_PARK_SEQ: begin
          if (walk == '0) begin
            if (walk_go) walk_n = WALK_W'(1);
          end else if (walk == WALK_LAST) begin
            st_n   = ST_PARKED_PAUSE;
            walk_n = '0;
          end else begin
            walk_n = walk + WALK_W'(1);
          end
        end
        default: begin
          if ((cmd == CMD_PARK) && port_sel) arm_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_PARKED_TLR;
      walk     <= '0;
      arm      <= 1'b0;
      hold_cnt <= '0;
    end else begin
      st       <= st_n;
      walk     <= walk_n;
      arm      <= arm_n;
      hold_cnt <= hold_n;
    end
  end

endmodule

// File: rtl/lp_tms_drive.sv
`timescale 1ns/1ps
module lp_tms_drive
  import lp_park_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  park_st_e          st,
  input  logic [WALK_W-1:0] walk,
  input  logic              walk_go,
  input  logic              unpark_go,
  input  logic              hold_done,
  input  logic              brg_tms,
  output logic              loc_tms,
  output logic              loc_tck_en
);

  logic tms_n, en_n;

  always_comb begin
    case (st)
      ST_UNPARKED: begin
        tms_n = brg_tms;
        en_n  = 1'b1;
      end
      ST_PARK_SEQ: begin
        if (walk == '0) tms_n = walk_go ? 1'b1 : brg_tms;
        else            tms_n = ~walk[0];
        en_n = 1'b1;
      end
      ST_PARKED_PAUSE: begin
        tms_n = unpark_go ? brg_tms : 1'b0;
        en_n  = unpark_go;
      end
      default: begin
        tms_n = unpark_go ? brg_tms : 1'b1;
        en_n  = unpark_go | ~hold_done;
      end
    endcase
  end

  // falling-edge launch so the local TAP samples a settled value
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_tms    <= 1'b1;
      loc_tck_en <= 1'b1;
    end else begin
      loc_tms    <= tms_n;
      loc_tck_en <= en_n;
    end
  end

endmodule

// File: rtl/lp_park_ctrl.sv
`timescale 1ns/1ps
module lp_park_ctrl
  import lp_park_pkg::*;
#(
  parameter int TLR_HOLD = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_park_pause,
  input  logic             cmd_goto_wait,
  input  logic             cmd_soft_reset,
  input  logic             port_sel,
  input  logic [TAP_W-1:0] brg_state,
  input  logic             brg_tms,
  output logic             loc_tms,
  output logic             loc_tck_en,
  output logic             in_chain
);

  park_cmd_e         cmd;
  park_st_e          st;
  logic [WALK_W-1:0] walk;
  logic              arm, hold_done, unpark_go, walk_go;

  lp_cmd_arb u_arb (
    .park_i (cmd_park_pause),
    .wait_i (cmd_goto_wait),
    .soft_i (cmd_soft_reset),
    .cmd_o  (cmd)
  );

  lp_park_fsm #(.HOLD(TLR_HOLD)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .port_sel  (port_sel),
    .brg_state (brg_state),
    .brg_tms   (brg_tms),
    .st        (st),
    .walk      (walk),
    .arm       (arm),
    .hold_done (hold_done),
    .unpark_go (unpark_go),
    .walk_go   (walk_go)
  );

  lp_tms_drive u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .walk       (walk),
    .walk_go    (walk_go),
    .unpark_go  (unpark_go),
    .hold_done  (hold_done),
    .brg_tms    (brg_tms),
    .loc_tms    (loc_tms),
    .loc_tck_en (loc_tck_en)
  );

  assign in_chain = (st == ST_UNPARKED) || ((st == ST_PARK_SEQ) && (walk == '0));

endmodule

// File: rtl/lp_park_ctrl_chk.sv
`timescale 1ns/1ps
module lp_park_ctrl_chk
  import lp_park_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_goto_wait,
  input logic              cmd_soft_reset,
  input logic [TAP_W-1:0]  brg_state,
  input logic              brg_tms,
  input logic              loc_tms,
  input logic              loc_tck_en,
  input logic              in_chain,
  input park_st_e          st,
  input logic [WALK_W-1:0] walk,
  input logic              arm,
  input logic              hold_done
);

  logic kill;
  assign kill = cmd_goto_wait | cmd_soft_reset;

  AST_CHAIN_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    in_chain |-> loc_tck_en); // R2

  AST_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARK_SEQ && walk == WALK_W'(WALK_LEN - 1) && !kill)
      |=> (st == ST_PARKED_PAUSE && !in_chain)); // R4

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED_PAUSE && !arm) |-> (!loc_tms && !loc_tck_en)); // R5

  AST_UNPARK_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED_PAUSE && arm && brg_state == TAP_PAUSE_DR && !kill)
      |=> (st == ST_UNPARKED && in_chain)); // R6

  AST_UNPARK_TLR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED_TLR && arm && hold_done && brg_state == TAP_RTI && !brg_tms && !kill)
      |=> (st == ST_UNPARKED && in_chain)); // R7

  AST_TLR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED_TLR && !(arm && hold_done)) |-> loc_tms); // R8

  AST_TLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED_TLR && hold_done && !arm) |-> !loc_tck_en); // R8

  AST_WAIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_goto_wait |=> !arm); // R9

  AST_SOFT_TO_TLR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_soft_reset |=> (st == ST_PARKED_TLR && !in_chain && !arm && !hold_done)); // R10

endmodule

bind lp_park_ctrl lp_park_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_goto_wait  (cmd_goto_wait),
  .cmd_soft_reset (cmd_soft_reset),
  .brg_state      (brg_state),
  .brg_tms        (brg_tms),
  .loc_tms        (loc_tms),
  .loc_tck_en     (loc_tck_en),
  .in_chain       (in_chain),
  .st             (st),
  .walk           (walk),
  .arm            (arm),
  .hold_done      (hold_done)
);

// File: tb/lp_park_ctrl_tb.sv
`timescale 1ns/1ps
module lp_park_ctrl_tb;

  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c_park = 1'b0, c_wait = 1'b0, c_soft = 1'b0, sel = 1'b0;
  logic [3:0] bs = 4'hF;
  logic       bt = 1'b1;
  logic       loc_tms, loc_tck_en, in_chain;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lp_park_ctrl #(.TLR_HOLD(H)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_park_pause (c_park),
    .cmd_goto_wait  (c_wait),
    .cmd_soft_reset (c_soft),
    .port_sel       (sel),
    .brg_state      (bs),
    .brg_tms        (bt),
    .loc_tms        (loc_tms),
    .loc_tck_en     (loc_tck_en),
    .in_chain       (in_chain)
  );

  // behavioural reference: 0 unparked, 1 parking, 2 parked pause, 3 parked reset
  int    m_st = 3, m_walk = 0, m_hold = 0;
  bit    m_arm = 0;
  bit    e_tms = 1, e_en = 1;
  string e_req = "R1";

  function automatic bit f_up();
    if (c_soft || c_wait || !m_arm) return 0;
    if (m_st == 2 && bs == 4'h3) return 1;
    if (m_st == 3 && m_hold >= H && bs == 4'hC && !bt) return 1;
    return 0;
  endfunction

  function automatic bit f_wg();
    return !(c_soft || c_wait) && m_st == 1 && m_walk == 0 && bs == 4'h5;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 3; m_walk = 0; m_hold = 0; m_arm = 0;
    end else begin
      int prev;
      bit up, wg;
      prev = m_st;
      up = f_up();
      wg = f_wg();
      if (c_soft) begin
        m_st = 3; m_walk = 0; m_hold = 0; m_arm = 0;
      end else if (c_wait) begin
        m_arm = 0;
        if (m_st <= 1) begin m_st = 3; m_walk = 0; m_hold = 0; end
      end else if (up) begin
        m_st = 0; m_arm = 0;
      end else if (m_st == 0) begin
        if (c_park) begin m_st = 1; m_walk = 0; end
      end else if (m_st == 1) begin
        if (m_walk == 0) begin if (wg) m_walk = 1; end
        else if (m_walk == 3) begin m_st = 2; m_walk = 0; end
        else m_walk++;
      end else begin
        if (c_park && sel) m_arm = 1;
      end
      if (prev == 3 && m_st == 3 && !c_soft && m_hold < H) m_hold++;
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_tms = 1; e_en = 1; e_req = "R1";
    end else begin
      bit up;
      up = f_up();
      case (m_st)
        0: begin e_tms = bt; e_en = 1; e_req = "R3"; end
        1: begin
          if (m_walk == 0) e_tms = f_wg() ? 1'b1 : bt;
          else             e_tms = (m_walk % 2 == 0);
          e_en = 1; e_req = "R4";
        end
        2: begin e_tms = up ? bt : 1'b0; e_en = up; e_req = up ? "R6" : "R5"; end
        default: begin
          e_tms = up ? bt : 1'b1; e_en = up || (m_hold < H); e_req = up ? "R7" : "R8";
        end
      endcase
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, just before the rising edge
  always @(negedge clk) begin
    #4;
    chk(e_req, "loc_tms", loc_tms, e_tms);
    chk(e_req, "loc_tck_en", loc_tck_en, e_en);
    chk("R2", "in_chain", in_chain, (m_st == 0) || (m_st == 1 && m_walk == 0));
  end

  task automatic drv(bit p, bit w, bit s, bit ps, logic [3:0] st, bit t);
    @(posedge clk); #1;
    c_park = p; c_wait = w; c_soft = s; sel = ps; bs = st; bt = t;
  endtask

  task automatic idle(int n, logic [3:0] st, bit t);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, st, t);
  endtask

  task automatic settle();
    @(negedge clk); #4;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    settle();
    chk("R1", "loc_tms in reset", loc_tms, 1'b1);
    chk("R1", "in_chain in reset", in_chain, 1'b0);
    rst_n = 1'b1;
    settle();
    chk("R1", "loc_tck_en after reset", loc_tck_en, 1'b1);
    chk("R1", "in_chain after reset", in_chain, 1'b0);

    idle(8, 4'hF, 1);
    settle();
    chk("R8", "tck gated after hold", loc_tck_en, 1'b0);
    chk("R8", "tms held high", loc_tms, 1'b1);

    // unpark from Parked-TLR
    drv(1, 0, 0, 1, 4'hF, 1);
    idle(2, 4'hC, 0);
    settle();
    chk("R7", "in chain after unpark", in_chain, 1'b1);

    for (int i = 0; i < 20; i++) drv(0, 0, 0, 0, 4'h2, 1'($urandom_range(0, 1)));

    // park in Pause-DR, duplicate park during wait is ignored
    drv(1, 0, 0, 0, 4'h2, 0);
    drv(1, 0, 0, 0, 4'h2, 0);
    idle(2, 4'h2, 0);
    drv(0, 0, 0, 0, 4'h1, 1);
    drv(0, 0, 0, 0, 4'h5, 1);
    idle(3, 4'h0, 0);
    idle(4, 4'h3, 1);
    settle();
    chk("R5", "parked pause tms", loc_tms, 1'b0);
    chk("R5", "parked pause tck", loc_tck_en, 1'b0);

    drv(1, 0, 0, 0, 4'h3, 1);
    idle(3, 4'h3, 1);
    settle();
    chk("R11", "unselected park ignored", in_chain, 1'b0);

    drv(1, 0, 0, 1, 4'h3, 1);
    idle(3, 4'h3, 1);
    settle();
    chk("R6", "unparked at Pause-DR", in_chain, 1'b1);

    // park again, arm, then disarm with return-to-wait
    drv(1, 0, 0, 0, 4'h3, 0);
    drv(0, 0, 0, 0, 4'h5, 0);
    idle(4, 4'h0, 0);
    drv(1, 0, 0, 1, 4'h0, 0);
    drv(0, 1, 0, 0, 4'h0, 0);
    idle(3, 4'h3, 1);
    settle();
    chk("R9", "disarmed port stays parked", in_chain, 1'b0);
    chk("R9", "parked pause kept", loc_tms, 1'b0);

    drv(0, 0, 1, 0, 4'h3, 0);
    idle(2, 4'h3, 0);
    settle();
    chk("R10", "soft reset tms high", loc_tms, 1'b1);
    chk("R10", "soft reset tck running", loc_tck_en, 1'b1);
    idle(8, 4'h3, 0);
    drv(0, 0, 1, 0, 4'h3, 0);
    idle(1, 4'h3, 0);
    settle();
    chk("R10", "hold restarted", loc_tck_en, 1'b1);

    // coincident commands: soft reset wins, park must not arm
    idle(8, 4'hF, 1);
    drv(1, 1, 1, 1, 4'hF, 1);
    idle(10, 4'hC, 0);
    settle();
    chk("R12", "coincident pulses do not arm", in_chain, 1'b0);

    // goto-wait on an unparked port
    drv(1, 0, 0, 1, 4'hC, 0);
    idle(2, 4'hC, 0);
    drv(0, 1, 0, 0, 4'h2, 0);
    idle(1, 4'h2, 0);
    settle();
    chk("R9", "unparked port sent to reset park", in_chain, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      int k;
      k = $urandom_range(0, 9);
      s = (k < 3) ? 4'hC : (k < 6) ? 4'h3 : (k < 8) ? 4'h5 : 4'($urandom_range(0, 15));
      drv($urandom_range(0, 99) < 6, $urandom_range(0, 99) < 2, $urandom_range(0, 99) < 1,
          1'($urandom_range(0, 1)), s, 1'($urandom_range(0, 1)));
    end
    idle(2, 4'hF, 1);
    settle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule